// File: doc/BRIEF.md
# Receive Buffer Release and Flow Controller

This block sits between a receive FIFO and a host-side packet engine. It decides whether a bulk-in request is answered with data or refused. A request is accepted with a full packet once enough bytes are buffered. It is also accepted, with whatever is buffered, when no byte has arrived for more than three character times, or at once when the low-latency control bit is set. An empty buffer is always refused.

The block also drives an active-low request-to-send line for automatic flow control. The line goes high (stop) when the FIFO fill reaches a programmable trigger level. It goes low again once host reads bring the fill back below that level.

Requests and responses are single-cycle strobes with no back-pressure. Every request strobe produces exactly one response strobe on the next clock edge, and the packet engine must accept it in that cycle. The FIFO count, the byte-written strobe and the character-time tick are plain status inputs.

Top module: `rx_release_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid_o` is 0 and `rts_n_o` is 0. The idle timeout starts not expired.
- R2: A request strobe in cycle t gives `rsp_valid_o`=1 for exactly cycle t+1. Without a request, `rsp_valid_o` is 0.
- R3: The packet size is 512 bytes when `hs_i`=1 and 64 bytes when `hs_i`=0, sampled with the request.
- R4: If the FIFO count is at least the packet size, the response is ACK (`rsp_ack_o`=1) with `rsp_len_o` equal to the packet size.
- R5: If the count is nonzero and below the packet size, `low_lat_i`=0 and the idle timeout has not expired, the response is NAK (`rsp_ack_o`=0).
- R6: The idle timeout expires on the fourth `char_tick_i` after the last byte write, or after reset. After that, a request with a nonzero count below the packet size is ACKed with `rsp_len_o` equal to the count.
- R7: A `byte_wr_i` pulse restarts the idle timeout. If a write and a tick arrive in the same cycle, the write wins and the tick is not counted.
- R8: With `low_lat_i`=1, any nonzero count below the packet size is ACKed at once with `rsp_len_o` equal to the count.
- R9: A request while the count is 0 is NAKed, even with `low_lat_i`=1 or the timeout expired.
- R10: `rts_n_o` is 1 in the cycle after the count is at or above `rts_thresh_i`, and 0 in the cycle after it is below.
- R11: A NAK response carries `rsp_len_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fifo_count_i | input | 11 | Bytes currently buffered in the receive FIFO |
| byte_wr_i | input | 1 | Pulse: one byte written into the FIFO |
| req_i | input | 1 | Pulse: host bulk-in request |
| hs_i | input | 1 | 1 = high-speed (512-byte packets), 0 = full-speed (64) |
| low_lat_i | input | 1 | Release any buffered data without waiting |
| char_tick_i | input | 1 | Pulse once per character time |
| rts_thresh_i | input | 11 | FIFO fill at which RTS# deasserts |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_ack_o | output | 1 | 1 = ACK with data, 0 = NAK |
| rsp_len_o | output | 11 | Bytes to transfer (0 on NAK) |
| rts_n_o | output | 1 | Active-low request-to-send |

## Verification
The bench targets the idle timeout edge. It expects a NAK after the third tick and an ACK after the fourth. A design that counts "at least three" would release one character early, and one that never saturates would wrap and NAK again. It drives a byte write in the same cycle as a tick, which catches a counter that lets the tick win. It also requests with an empty FIFO under low latency and after the timeout, where a careless release rule would ACK a zero-length packet. Both packet sizes are probed exactly at and one below the boundary, and the RTS line is checked at, above and one below the trigger, which exposes an off-by-one compare.

// File: rtl/rxrel_pkg.sv
package rxrel_pkg;
  typedef enum logic [1:0] {
    REL_NAK  = 2'd0,
    REL_FULL = 2'd1,
    REL_PART = 2'd2
  } rel_kind_e;
endpackage

// File: rtl/rxrel_idle_timer.sv
module rxrel_idle_timer #(
  parameter int IDLE_CHARS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_wr_i,
  input  logic char_tick_i,
  output logic expired_o
);
  localparam int LIMIT  = IDLE_CHARS + 1;
  localparam int IDLE_W = $clog2(LIMIT + 1);
  localparam logic [IDLE_W-1:0] LIMIT_V = IDLE_W'(LIMIT);

  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (byte_wr_i) begin
      cnt_q <= '0;
    end else if (char_tick_i && (cnt_q != LIMIT_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == LIMIT_V);

  AST_IDLE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_wr_i |=> !expired_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !byte_wr_i) |=> expired_o); // R6
endmodule

// File: rtl/rxrel_decider.sv
module rxrel_decider
  import rxrel_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int FS_PKT = 64,
  parameter int HS_PKT = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             hs_i,
  input  logic             low_lat_i,
  input  logic             expired_i,
  output logic             rsp_valid_o,
  output logic             rsp_ack_o,
  output logic [CNT_W-1:0] rsp_len_o
);
  localparam logic [CNT_W-1:0] FS_V = CNT_W'(FS_PKT);
  localparam logic [CNT_W-1:0] HS_V = CNT_W'(HS_PKT);

  logic [CNT_W-1:0] pkt_sz;
  rel_kind_e        kind;

  always_comb begin
    pkt_sz = hs_i ? HS_V : FS_V;
    if (count_i == '0)                kind = REL_NAK;
    else if (count_i >= pkt_sz)       kind = REL_FULL;
    else if (low_lat_i || expired_i)  kind = REL_PART;
    else                              kind = REL_NAK;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ack_o   <= 1'b0;
      rsp_len_o   <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        unique case (kind)
          REL_FULL: begin rsp_ack_o <= 1'b1; rsp_len_o <= pkt_sz;  end
          REL_PART: begin rsp_ack_o <= 1'b1; rsp_len_o <= count_i; end
          default:  begin rsp_ack_o <= 1'b0; rsp_len_o <= '0;      end
        endcase
      end else begin
        rsp_ack_o <= 1'b0;
        rsp_len_o <= '0;
      end
    end
  end

  AST_FULL_PACKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && count_i >= pkt_sz) |=> (rsp_ack_o && rsp_len_o == $past(pkt_sz))); // R4
  AST_EMPTY_NAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && count_i == '0) |=> !rsp_ack_o); // R9
  AST_LOWLAT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && low_lat_i && count_i != '0) |=> rsp_ack_o); // R8
  AST_NAK_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ack_o) |-> (rsp_len_o == '0)); // R11
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ack_o |-> (rsp_len_o != '0 && rsp_len_o <= HS_V)); // R3
endmodule

// File: rtl/rxrel_rts_ctrl.sv
module rxrel_rts_ctrl #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             rts_n_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) rts_n_o <= 1'b0;
    else         rts_n_o <= (count_i >= thresh_i);
  end

  AST_RTS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i >= thresh_i) |=> rts_n_o); // R10
  AST_RTS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i < thresh_i) |=> !rts_n_o); // R10
endmodule

// File: rtl/rx_release_ctrl.sv
module rx_release_ctrl #(
  parameter int FIFO_DEPTH = 1024,
  parameter int FS_PKT     = 64,
  parameter int HS_PKT     = 512,
  parameter int IDLE_CHARS = 3,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fifo_count_i,
  input  logic             byte_wr_i,
  input  logic             req_i,
  input  logic             hs_i,
  input  logic             low_lat_i,
  input  logic             char_tick_i,
  input  logic [CNT_W-1:0] rts_thresh_i,
  output logic             rsp_valid_o,
  output logic             rsp_ack_o,
  output logic [CNT_W-1:0] rsp_len_o,
  output logic             rts_n_o
);
  logic idle_expired;

  rxrel_idle_timer #(.IDLE_CHARS(IDLE_CHARS)) u_idle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_wr_i   (byte_wr_i),
    .char_tick_i (char_tick_i),
    .expired_o   (idle_expired)
  );

  rxrel_decider #(.CNT_W(CNT_W), .FS_PKT(FS_PKT), .HS_PKT(HS_PKT)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .count_i     (fifo_count_i),
    .hs_i        (hs_i),
    .low_lat_i   (low_lat_i),
    .expired_i   (idle_expired),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ack_o   (rsp_ack_o),
    .rsp_len_o   (rsp_len_o)
  );

  rxrel_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .count_i  (fifo_count_i),
    .thresh_i (rts_thresh_i),
    .rts_n_o  (rts_n_o)
  );

  AST_ONE_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_i)); // R2
  AST_ALWAYS_RESPOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o); // R2
endmodule

// File: tb/tb_rx_release_ctrl.sv
module tb_rx_release_ctrl;
  localparam int CNT_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] fifo_count = '0;
  logic             byte_wr = 1'b0;
  logic             req = 1'b0;
  logic             hs = 1'b0;
  logic             low_lat = 1'b0;
  logic             tick = 1'b0;
  logic [CNT_W-1:0] thresh = 11'd100;
  logic             rsp_valid, rsp_ack, rts_n;
  logic [CNT_W-1:0] rsp_len;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_release_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_count_i(fifo_count), .byte_wr_i(byte_wr),
    .req_i(req), .hs_i(hs), .low_lat_i(low_lat), .char_tick_i(tick),
    .rts_thresh_i(thresh), .rsp_valid_o(rsp_valid), .rsp_ack_o(rsp_ack),
    .rsp_len_o(rsp_len), .rts_n_o(rts_n)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // Issue one request; sample the response on the following negedge.
  task automatic do_req(input string tag, input int exp_ack, input int exp_len);
    req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    check({tag, " valid"}, rsp_valid, 1);
    check({tag, " ack"}, rsp_ack, exp_ack);
    check({tag, " len"}, rsp_len, exp_len);
  endtask

  task automatic pulse(input bit wr, input bit tk);
    byte_wr = wr; tick = tk;
    @(posedge clk); @(negedge clk);
    byte_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid in reset", rsp_valid, 0);
    check("R1 rts in reset", rts_n, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 valid after reset", rsp_valid, 0);
    check("R1 rts after reset", rts_n, 0);
    fifo_count = 11'd5;
    do_req("R1 timeout not expired", 0, 0);
  endtask

  task automatic t_full;
    hs = 1'b0; fifo_count = 11'd64;
    do_req("R4 FS at 64", 1, 64);
    @(posedge clk); @(negedge clk);
    check("R2 single-cycle valid", rsp_valid, 0);
    fifo_count = 11'd300;
    do_req("R3 FS caps at 64", 1, 64);
    hs = 1'b1;
    do_req("R5 HS 300 below 512", 0, 0);
    fifo_count = 11'd512;
    do_req("R4 HS at 512", 1, 512);
    fifo_count = 11'd1000;
    do_req("R3 HS caps at 512", 1, 512);
    hs = 1'b0; fifo_count = 11'd63;
    do_req("R5 FS 63 NAK", 0, 0);
  endtask

  task automatic t_idle;
    fifo_count = 11'd10;
    pulse(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
    do_req("R6 three ticks still NAK", 0, 0);
    pulse(1'b0, 1'b1);
    do_req("R6 fourth tick releases", 1, 10);
    for (int i = 0; i < 20; i++) pulse(1'b0, 1'b1);
    do_req("R6 saturated stays released", 1, 10);
    pulse(1'b1, 1'b1);
    do_req("R7 write wins over tick", 0, 0);
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    do_req("R7 write restarts count", 0, 0);
  endtask

  task automatic t_lowlat;
    pulse(1'b1, 1'b0);
    low_lat = 1'b1; fifo_count = 11'd1;
    do_req("R8 low latency one byte", 1, 1);
    fifo_count = 11'd0;
    do_req("R9 empty with low latency", 0, 0);
    low_lat = 1'b0;
    for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1);
    do_req("R9 empty after timeout", 0, 0);
  endtask

  task automatic t_rts;
    thresh = 11'd100; fifo_count = 11'd99;
    @(posedge clk); @(negedge clk);
    check("R10 below threshold asserted", rts_n, 0);
    fifo_count = 11'd100;
    @(posedge clk); @(negedge clk);
    check("R10 at threshold deasserted", rts_n, 1);
    fifo_count = 11'd150;
    @(posedge clk); @(negedge clk);
    check("R10 above threshold deasserted", rts_n, 1);
    fifo_count = 11'd99;
    @(posedge clk); @(negedge clk);
    check("R10 drained reasserted", rts_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_full();
    t_idle();
    t_lowlat();
    t_rts();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule